// File: doc/BRIEF.md
# Memory Channel Control Register Front End

This block sits between a narrow 16-bit register write bus and a memory controller whose control registers are 32 bits wide. A staging register holds the upper half of the next 32-bit word. Every write to the controller register group is then formed from the staging value and the 16-bit bus data. The staging value stays in place after use, so a run of writes that share an upper half needs only one staging write.

From these 32-bit words the block keeps one control state per memory channel (pause, init or enable) and a matching state for auto-refresh. It emits a one-cycle init strobe whenever a channel enters init. It also forwards direct command words to the memory address and control lines for the power-up sequence. It holds a start page per channel and a tiling word per channel pair.

A read-back port returns the register contents. At the direct-command address it returns two free-running counters of page-read and page-write commands. Even-numbered channels are memory write channels and odd-numbered channels are memory read channels. The controller that consumes these outputs decides what each direction means.

Top module: `memctl_regfront`

## Requirements
- R1: After a synchronous active-low reset, every channel state and the refresh state are pause (code 0), no init strobe or command strobe is high, and the staging register, start pages, tiling words and both page counters read zero.
- R2: A write to address 0x00 loads the staging register. Each controller write uses the 32-bit word {staging, bus data}. The staging value is kept after use, and only a write to 0x00 changes it.
- R3: A write to address 0x01 updates channel n from word bits [2n+1:2n] (n = 0..7) and the refresh state from word bits [17:16]. Code 0 selects pause, 1 selects init and 2 selects enable. Code 3 leaves that field's state unchanged.
- R4: When a channel-state write moves channel n into init from pause or enable, its init strobe is high for exactly the one cycle in which the new state first appears. A write of init to a channel already in init gives no strobe.
- R5: A write to address 0x02 places the 32-bit word on the direct-command output from the next cycle on and holds it there. The command strobe is high for that one cycle only.
- R6: A write to address 0x10+n sets the start page of channel n to word bits [11:0].
- R7: A write to address 0x20+p sets the tiling of channel pair p (channels 2p and 2p+1). The burst count (8-word bursts per write) comes from word [7:0], the address shift after each burst from [15:8], and the write count before the alternate shift from [31:16].
- R8: Reading address 0x02 returns the page-read command count in [15:8] and the page-write command count in [7:0]. Each count rises by one for every cycle its event input is high and wraps from 255 to 0.
- R9: Read-back returns the staging value at 0x00, the channel-state vector at 0x01, the zero-extended start page at 0x10+n and the low half of the tiling word at 0x20+p. Any other address reads as zero.
- R10: A cycle with the write enable low, or a write to an unmapped address, changes no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 16 | Register write data (lower half of the word) |
| rd_addr | input | 6 | Read-back address |
| rd_data | output | 16 | Read-back data, combinational from rd_addr |
| pg_wr_evt | input | 1 | One page-write command issued this cycle |
| pg_rd_evt | input | 1 | One page-read command issued this cycle |
| ch_state | output | 16 | Per-channel state code, channel n at [2n+1:2n] |
| ch_init_pulse | output | 8 | One-cycle strobe per channel on entry to init |
| refresh_state | output | 2 | Auto-refresh state code |
| dcmd_valid | output | 1 | Direct command issued (one cycle) |
| dcmd_word | output | 32 | Direct command to memory address and control lines |
| start_page | output | 96 | 12-bit start page per channel, channel n at [12n+11:12n] |
| tile_bursts | output | 32 | Bursts per write, pair p at [8p+7:8p] |
| tile_shift | output | 32 | Address shift after burst, pair p at [8p+7:8p] |
| tile_span | output | 64 | Writes before alternate shift, pair p at [16p+15:16p] |

## Verification
A wrong internal state here does not hide. A channel field that moved when it should have held, or failed to move, shows on ch_state on the first cycle after the write, and the init strobe either appears or goes missing in that same cycle. A corrupted staging value shows up in the upper half of the next direct command, and at once on read-back of 0x00. A counter that skipped or doubled an event shows as a wrong count the next time 0x02 is read. The bench sweeps every channel against every previous state and every code, and pushes the counters through their wrap.

// File: rtl/mcc_pkg.sv
// Package: shared codes and the register address map of the front end.
// Assumes a 6-bit register address space.
package mcc_pkg;

    localparam int ADDR_W = 6;
    localparam int BUS_W  = 16;
    localparam int WORD_W = 2 * BUS_W;

    // per-field control codes; KEEP leaves the state as it is
    typedef enum logic [1:0] {
        CH_PAUSE  = 2'd0,
        CH_INIT   = 2'd1,
        CH_ENABLE = 2'd2,
        CH_KEEP   = 2'd3
    } ch_code_e;

    localparam logic [ADDR_W-1:0] A_STAGE     = 6'h00;
    localparam logic [ADDR_W-1:0] A_CHST      = 6'h01;
    localparam logic [ADDR_W-1:0] A_DCMD      = 6'h02;
    localparam logic [ADDR_W-1:0] A_PAGE_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] A_TILE_BASE = 6'h20;

endpackage

// File: rtl/mcc_write_stage.sv
// Module: holds the sticky upper-half staging register, assembles 32-bit
// words, decodes the write address and issues direct commands.
// Assumes NCH <= 16 and NPAIR <= 16 so the address ranges do not overlap.
module mcc_write_stage
    import mcc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NPAIR = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    output logic [BUS_W-1:0]    stage_q,
    output logic [WORD_W-1:0]   word,
    output logic                sel_chst,
    output logic [NCH-1:0]      sel_page,
    output logic [NPAIR-1:0]    sel_tile,
    output logic                dcmd_valid,
    output logic [WORD_W-1:0]   dcmd_word
);

    logic sel_stage;
    logic sel_dcmd;

    // word seen by every controller register: staged upper half plus bus data
    assign word = {stage_q, wr_data};

    // address decode of the write bus
    always_comb begin
        sel_stage = wr_en && (wr_addr == A_STAGE);
        sel_chst  = wr_en && (wr_addr == A_CHST);
        sel_dcmd  = wr_en && (wr_addr == A_DCMD);
        for (int i = 0; i < NCH; i++) begin
            sel_page[i] = wr_en && (wr_addr == (A_PAGE_BASE + ADDR_W'(i)));
        end
        for (int p = 0; p < NPAIR; p++) begin
            sel_tile[p] = wr_en && (wr_addr == (A_TILE_BASE + ADDR_W'(p)));
        end
    end

    // staging register: changed only by its own address, never cleared by use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (sel_stage) begin
            stage_q <= wr_data;
        end
    end

    // direct command: word held on the lines, strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcmd_valid <= 1'b0;
            dcmd_word  <= '0;
        end else begin
            dcmd_valid <= sel_dcmd;
            if (sel_dcmd) begin
                dcmd_word <= word;
            end
        end
    end

endmodule

// File: rtl/mcc_field_ctl.sv
// Module: one channel control field (pause/init/enable) with an entry strobe
// into init. Assumes code KEEP means no change.
module mcc_field_ctl
    import mcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [1:0]  code,
    output logic [1:0]  state,
    output logic        init_pulse
);

    logic enter_init;

    // a new init only counts when the field is not already in init
    assign enter_init = load && (code == CH_INIT) && (state != CH_INIT);

    // state register and aligned init strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CH_PAUSE;
            init_pulse <= 1'b0;
        end else begin
            init_pulse <= enter_init;
            if (load && (code != CH_KEEP)) begin
                state <= code;
            end
        end
    end

endmodule

// File: rtl/mcc_param_bank.sv
// Module: per-channel start pages and per-pair tiling words.
// Assumes PG_W <= 16 so a start page fits in the lower bus half.
module mcc_param_bank
    import mcc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NPAIR = 4,
    parameter int PG_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       word,
    input  logic [NCH-1:0]          sel_page,
    input  logic [NPAIR-1:0]        sel_tile,
    output logic [NCH*PG_W-1:0]     start_page,
    output logic [NPAIR*8-1:0]      tile_bursts,
    output logic [NPAIR*8-1:0]      tile_shift,
    output logic [NPAIR*16-1:0]     tile_span
);

    for (genvar i = 0; i < NCH; i++) begin : g_page
        // start page of channel i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_page[i*PG_W +: PG_W] <= '0;
            end else if (sel_page[i]) begin
                start_page[i*PG_W +: PG_W] <= word[PG_W-1:0];
            end
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_tile
        // tiling fields of channel pair p
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tile_bursts[p*8 +: 8]  <= '0;
                tile_shift[p*8 +: 8]   <= '0;
                tile_span[p*16 +: 16]  <= '0;
            end else if (sel_tile[p]) begin
                tile_bursts[p*8 +: 8]  <= word[7:0];
                tile_shift[p*8 +: 8]   <= word[15:8];
                tile_span[p*16 +: 16]  <= word[31:16];
            end
        end
    end

endmodule

// File: rtl/mcc_page_counter.sv
// Module: free-running wrap-around counters of page-read and page-write
// commands. Assumes at most one event of each kind per cycle.
module mcc_page_counter #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr_evt,
    input  logic              pg_rd_evt,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [CNT_W-1:0]  rd_cnt
);

    // count both event kinds independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (pg_wr_evt) wr_cnt <= wr_cnt + 1'b1;
            if (pg_rd_evt) rd_cnt <= rd_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/memctl_regfront.sv
// Module: top of the register front end. Presents 32-bit memory-controller
// control registers over a 16-bit bus and returns read-back data.
// Assumes NCH is even and NCH <= 8 so all state fields sit in [15:0].
module memctl_regfront
    import mcc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int PG_W  = 12,
    parameter int CNT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [5:0]                    wr_addr,
    input  logic [15:0]                   wr_data,
    input  logic [5:0]                    rd_addr,
    output logic [15:0]                   rd_data,
    input  logic                          pg_wr_evt,
    input  logic                          pg_rd_evt,
    output logic [2*NCH-1:0]              ch_state,
    output logic [NCH-1:0]                ch_init_pulse,
    output logic [1:0]                    refresh_state,
    output logic                          dcmd_valid,
    output logic [31:0]                   dcmd_word,
    output logic [NCH*PG_W-1:0]           start_page,
    output logic [(NCH/2)*8-1:0]          tile_bursts,
    output logic [(NCH/2)*8-1:0]          tile_shift,
    output logic [(NCH/2)*16-1:0]         tile_span
);

    localparam int NPAIR = NCH / 2;

    logic [BUS_W-1:0]  stage_q;
    logic [WORD_W-1:0] word;
    logic              sel_chst;
    logic [NCH-1:0]    sel_page;
    logic [NPAIR-1:0]  sel_tile;
    logic [CNT_W-1:0]  wr_cnt_q;
    logic [CNT_W-1:0]  rd_cnt_q;

    mcc_write_stage #(.NCH(NCH), .NPAIR(NPAIR)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .stage_q    (stage_q),
        .word       (word),
        .sel_chst   (sel_chst),
        .sel_page   (sel_page),
        .sel_tile   (sel_tile),
        .dcmd_valid (dcmd_valid),
        .dcmd_word  (dcmd_word)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        mcc_field_ctl u_field (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (sel_chst),
            .code       (word[2*n +: 2]),
            .state      (ch_state[2*n +: 2]),
            .init_pulse (ch_init_pulse[n])
        );
    end

    // refresh control field, taken from the staged upper half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_state <= CH_PAUSE;
        end else if (sel_chst && (word[17:16] != CH_KEEP)) begin
            refresh_state <= word[17:16];
        end
    end

    mcc_param_bank #(.NCH(NCH), .NPAIR(NPAIR), .PG_W(PG_W)) u_params (
        .clk         (clk),
        .rst_n       (rst_n),
        .word        (word),
        .sel_page    (sel_page),
        .sel_tile    (sel_tile),
        .start_page  (start_page),
        .tile_bursts (tile_bursts),
        .tile_shift  (tile_shift),
        .tile_span   (tile_span)
    );

    mcc_page_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_wr_evt (pg_wr_evt),
        .pg_rd_evt (pg_rd_evt),
        .wr_cnt    (wr_cnt_q),
        .rd_cnt    (rd_cnt_q)
    );

    // read-back multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STAGE) rd_data = stage_q;
        if (rd_addr == A_CHST)  rd_data = 16'(ch_state);
        if (rd_addr == A_DCMD)  rd_data = {rd_cnt_q, wr_cnt_q};
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == (A_PAGE_BASE + ADDR_W'(i))) begin
                rd_data = 16'(start_page[i*PG_W +: PG_W]);
            end
        end
        for (int p = 0; p < NPAIR; p++) begin
            if (rd_addr == (A_TILE_BASE + ADDR_W'(p))) begin
                rd_data = {tile_shift[p*8 +: 8], tile_bursts[p*8 +: 8]};
            end
        end
    end

endmodule

// File: rtl/memctl_regfront_chk.sv
// Module: property checker for the front end, bound to the top module.
// Assumes NCH <= 8 so every field sits in the bus data half.
module memctl_regfront_chk
    import mcc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [15:0]       stage_q,
    input  logic [2*NCH-1:0]  ch_state,
    input  logic [NCH-1:0]    ch_init_pulse,
    input  logic              dcmd_valid,
    input  logic              pg_wr_evt,
    input  logic [CNT_W-1:0]  wr_cnt
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ch_state == '0 && ch_init_pulse == '0 && !dcmd_valid));

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_STAGE) |=> $stable(stage_q));

    // R5
    dcmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcmd_valid |-> $past(wr_en && wr_addr == A_DCMD));

    // R8
    wr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_cnt == $past(wr_cnt) + CNT_W'($past(pg_wr_evt))));

    for (genvar n = 0; n < NCH; n++) begin : g_field
        // R3
        keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_CHST && wr_data[2*n +: 2] == CH_KEEP)
            |=> $stable(ch_state[2*n +: 2]));

        // R4
        pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_init_pulse[n] |-> (ch_state[2*n +: 2] == CH_INIT));

        // R4
        pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_init_pulse[n] |=> !ch_init_pulse[n]);
    end

endmodule

bind memctl_regfront memctl_regfront_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .stage_q       (stage_q),
    .ch_state      (ch_state),
    .ch_init_pulse (ch_init_pulse),
    .dcmd_valid    (dcmd_valid),
    .pg_wr_evt     (pg_wr_evt),
    .wr_cnt        (wr_cnt_q)
);

// File: tb/tb_memctl_regfront.sv
module tb_memctl_regfront;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [5:0]   rd_addr = '0;
    logic [15:0]  rd_data;
    logic         pg_wr_evt = 1'b0;
    logic         pg_rd_evt = 1'b0;
    logic [15:0]  ch_state;
    logic [7:0]   ch_init_pulse;
    logic [1:0]   refresh_state;
    logic         dcmd_valid;
    logic [31:0]  dcmd_word;
    logic [95:0]  start_page;
    logic [31:0]  tile_bursts;
    logic [31:0]  tile_shift;
    logic [63:0]  tile_span;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int st [8];
    int rf;
    int wcnt;
    int rcnt;

    always #4 clk = ~clk;

    memctl_regfront dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pg_wr_evt(pg_wr_evt), .pg_rd_evt(pg_rd_evt), .ch_state(ch_state),
        .ch_init_pulse(ch_init_pulse), .refresh_state(refresh_state),
        .dcmd_valid(dcmd_valid), .dcmd_word(dcmd_word),
        .start_page(start_page), .tile_bursts(tile_bursts),
        .tile_shift(tile_shift), .tile_span(tile_span)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic events(input int nw, input int nr);
        int n;
        n = (nw > nr) ? nw : nr;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pg_wr_evt = (k < nw);
            pg_rd_evt = (k < nr);
        end
        @(negedge clk);
        pg_wr_evt = 1'b0; pg_rd_evt = 1'b0;
        wcnt = (wcnt + nw) % 256;
        rcnt = (rcnt + nr) % 256;
    endtask

    function automatic logic [15:0] exp_state();
        logic [15:0] e;
        for (int i = 0; i < 8; i++) e[2*i +: 2] = st[i][1:0];
        return e;
    endfunction

    function automatic logic [15:0] keep_but(input int n, input int v);
        logic [15:0] d;
        d = 16'hFFFF;
        d[2*n +: 2] = v[1:0];
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] pv;
        for (int i = 0; i < 8; i++) st[i] = 0;
        rf = 0; wcnt = 0; rcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ch_state", ch_state, 0);
        check("R1 refresh", refresh_state, 0);
        check("R1 pulses", {ch_init_pulse, dcmd_valid}, 0);
        check("R1 params", {start_page, tile_span}, 0);
        rd(6'h02, r); check("R1 counters", r, 0);
        rd(6'h00, r); check("R1 staging", r, 0);

        // R3 R4 sweep: every channel, every prior state, every code
        wr(6'h00, 16'h0003);
        for (int n = 0; n < 8; n++) begin
            for (int p = 0; p < 3; p++) begin
                for (int v = 0; v < 4; v++) begin
                    wr(6'h01, keep_but(n, p));
                    st[n] = p;
                    wr(6'h01, keep_but(n, v));
                    pv = '0;
                    if (v == 1 && p != 1) pv[n] = 1'b1;
                    if (v != 3) st[n] = v;
                    check("R3 field state", ch_state, exp_state());
                    check("R4 init strobe", ch_init_pulse, pv[7:0]);
                end
            end
        end
        @(negedge clk);
        check("R4 strobe one cycle", ch_init_pulse, 0);
        rd(6'h01, r); check("R9 state readback", r, exp_state());

        // R3 refresh field from staged upper half
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 4; v++) begin
                wr(6'h00, 16'(p)); wr(6'h01, 16'hFFFF); rf = p;
                wr(6'h00, 16'(v)); wr(6'h01, 16'hFFFF);
                if (v != 3) rf = v;
                check("R3 refresh", refresh_state, rf[1:0]);
                check("R3 refresh leaves channels", ch_state, exp_state());
            end
        end

        // R2 R5 sticky staging and direct command
        wr(6'h00, 16'hABCD);
        wr(6'h02, 16'h1234);
        check("R5 dcmd strobe", dcmd_valid, 1);
        check("R2 R5 dcmd word", dcmd_word, 32'hABCD1234);
        @(negedge clk);
        check("R5 strobe one cycle", dcmd_valid, 0);
        check("R5 word held", dcmd_word, 32'hABCD1234);
        wr(6'h02, 16'h5678);
        check("R2 staging kept", dcmd_word, 32'hABCD5678);
        rd(6'h00, r); check("R9 staging readback", r, 16'hABCD);

        // R6 start pages
        for (int i = 0; i < 8; i++) begin
            wr(6'h10 + 6'(i), 16'(i * 16'h0123 + 16'hF456));
        end
        for (int i = 0; i < 8; i++) begin
            logic [11:0] e;
            e = 12'(i * 16'h0123 + 16'hF456);
            check("R6 start page", start_page[12*i +: 12], e);
            rd(6'h10 + 6'(i), r); check("R9 page readback", r, {4'h0, e});
        end

        // R7 tiling words
        for (int p = 0; p < 4; p++) begin
            wr(6'h00, 16'(16'h1000 + p * 16'h0111));
            wr(6'h20 + 6'(p), 16'(16'h0F02 + p * 16'h0101));
        end
        for (int p = 0; p < 4; p++) begin
            logic [15:0] lo;
            lo = 16'(16'h0F02 + p * 16'h0101);
            check("R7 bursts", tile_bursts[8*p +: 8], lo[7:0]);
            check("R7 shift", tile_shift[8*p +: 8], lo[15:8]);
            check("R7 span", tile_span[16*p +: 16], 16'(16'h1000 + p * 16'h0111));
            rd(6'h20 + 6'(p), r); check("R9 tile readback", r, lo);
        end

        // R8 counters, independent and wrapping
        events(5, 3);
        rd(6'h02, r); check("R8 counters", r, {8'(rcnt), 8'(wcnt)});
        events(259, 2);
        rd(6'h02, r); check("R8 write wrap", r, {8'(rcnt), 8'(wcnt)});
        events(0, 300);
        rd(6'h02, r); check("R8 read wrap", r, {8'(rcnt), 8'(wcnt)});
        rd(6'h3A, r); check("R9 unmapped read", r, 0);

        // R10 unmapped write and disabled write
        wr(6'h3A, 16'h0000);
        rd(6'h00, r); check("R10 unmapped staging", r, 16'h1333);
        check("R10 unmapped state", ch_state, exp_state());
        check("R10 unmapped dcmd", {dcmd_valid, dcmd_word}, {1'b0, 32'hABCD5678});
        @(negedge clk);
        wr_addr = 6'h00; wr_data = 16'h0000;
        @(negedge clk);
        wr_addr = 6'h01;
        @(negedge clk);
        rd(6'h00, r); check("R10 disabled staging", r, 16'h1333);
        check("R10 disabled state", ch_state, exp_state());

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule